// File: doc/BRIEF.md
# Completion Ring Poster with Phase Tag

This block sits between the command execution logic of a storage controller and host memory. The execution logic hands it one completion record at a time: a status code, the command identifier, the submission queue identifier and the submission queue head value. The block turns each record into a 16-byte entry and writes that entry into the next slot of a circular completion ring in host memory. Records may arrive in any order relative to the commands that produced them. The command identifier lets the host pair each result with its request, and the queue identifier lets several submission queues share one ring.

Every entry holds a phase tag. Host software polls memory rather than registers, and it treats an entry as new when the entry's tag matches the phase it currently expects. The block keeps the tail slot and the current phase, and it inverts the phase each time the tail wraps to slot zero. The host frees slots by writing a new head index through a doorbell input. The block keeps one slot empty, so the ring counts as full when advancing the tail would land on the head. While the ring is full it holds the record input off.

The memory write leaves through a valid/ready port. When an entry's write is accepted and interrupts are enabled, the block raises an interrupt request for exactly one cycle.

A state machine controls the sequence and has three states:
- `ST_WAIT` accepts a record when the ring is not full (transition *accept*).
- `ST_WRITE` presents the entry until the memory port takes it (transition *written*; it stays in this state on *stall*).
- `ST_SIGNAL` lasts one cycle, drives the interrupt request and then returns to `ST_WAIT` (transition *done*).

Top module: `cq_poster`

## Requirements
- R1: Each entry is 128 bits. Bits 63:0 are zero, 79:64 hold the submission queue head, 95:80 the submission queue identifier, 111:96 the command identifier, 112 the phase tag and 127:113 the 15-bit status. The write address is `ring_base + 16 * slot`.
- R2: Entries are written to consecutive slots in the order their records are accepted. The slot index advances by one on each accepted write and wraps from DEPTH-1 to 0.
- R3: The phase tag is 1 after reset and inverts each time the slot index wraps from DEPTH-1 to 0. Every entry carries the phase that is current for its slot.
- R4: When (tail + 1) mod DEPTH equals the host head, `cpl_ready` stays low and no entry is written until the head moves.
- R5: A doorbell with `db_head` below DEPTH sets the host head. A doorbell value of DEPTH or more is ignored, and the full state it could have cleared remains.
- R6: Once `wr_valid` is high it stays high, with `wr_addr` and `wr_data` unchanged, until `wr_ready` is seen.
- R7: `irq_req` is high for exactly the one cycle after a write is accepted, and only if `irq_en` is high. It never rises at any other time.
- R8: Only one entry is in flight. `cpl_ready` is low from the cycle after an accept until the interrupt cycle has passed, and an accept is followed by `wr_valid` in the next cycle.
- R9: After reset `cpl_ready` is high, and `wr_valid` and `irq_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Enables the per-entry interrupt request |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| cpl_valid | input | 1 | Completion record offered |
| cpl_ready | output | 1 | Completion record accepted when high with valid |
| cpl_cid | input | 16 | Command identifier |
| cpl_sqid | input | 16 | Source submission queue identifier |
| cpl_sqhd | input | 16 | Submission queue head at time of posting |
| cpl_status | input | 15 | Completion status |
| db_valid | input | 1 | Host head doorbell write |
| db_head | input | IDX_W | New host head slot index |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory write accepted when high with valid |
| wr_addr | output | ADDR_W | Memory write byte address |
| wr_data | output | 128 | Completion entry |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
Records with distinct, out-of-order command identifiers and different queue identifiers are posted with the write port always ready, and then with the write port stalling on a regular pattern. These two runs separate correct field packing and ordering from wrong behaviour while the block holds a request. The ring is filled until it blocks, and the block receives an out-of-range doorbell and then a valid one, which exposes an off-by-one in the full test and any acceptance of bad head values. The tail is driven across slot zero twice, so the phase is seen to go from 1 to 0 and back to 1. Interrupts are disabled for part of the run, which shows whether the request obeys the enable.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int ENTRY_W  = 128;
    localparam int ID_W     = 16;
    localparam int STATUS_W = 15;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_SIGNAL = 2'd2
    } cq_state_e;

    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic [ID_W-1:0]     cid;
        logic [ID_W-1:0]     sqid;
        logic [ID_W-1:0]     sqhd;
    } cq_rec_t;

endpackage

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr #(
    parameter int DEPTH = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             db_valid,
    input  logic [IDX_W-1:0] db_head,
    output logic [IDX_W-1:0] tail,
    output logic             phase,
    output logic             full
);

    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W:0]   LIMIT = (IDX_W + 1)'(DEPTH);

    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail_next;
    logic             wrap;
    logic             head_ok;

    always_comb begin
        wrap      = (tail == LAST);
        tail_next = wrap ? '0 : tail + 1'b1;
        full      = (tail_next == head);
        head_ok   = db_valid && ({1'b0, db_head} < LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail  <= '0;
            phase <= 1'b1;
            head  <= '0;
        end else begin
            if (advance) begin
                tail <= tail_next;
                if (wrap) begin
                    phase <= ~phase;
                end
            end
            if (head_ok) begin
                head <= db_head;
            end
        end
    end

    // R3
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && tail == LAST) |=> (phase != $past(phase)));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance || tail != LAST) |=> $stable(phase));

    // R5
    head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, head} < LIMIT));

    // R5
    bad_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && ({1'b0, db_head} >= LIMIT)) |=> $stable(head));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (tail_next != head));

endmodule

// File: rtl/cq_entry_reg.sv
module cq_entry_reg
    import cq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  cq_rec_t            rec,
    input  logic               phase,
    input  logic [IDX_W-1:0]   slot,
    input  logic [ADDR_W-1:0]  base,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [ENTRY_W-1:0] wr_data
);

    localparam int OFS_W = IDX_W + 4;

    logic [ENTRY_W-1:0] packed_entry;
    logic [ADDR_W-1:0]  slot_addr;

    always_comb begin
        packed_entry = {rec.status, phase, rec.cid, rec.sqid, rec.sqhd, 64'h0};
        slot_addr    = base + ADDR_W'({slot, 4'b0000});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (capture) begin
            wr_addr <= slot_addr;
            wr_data <= packed_entry;
        end
    end

    // R1
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data[63:0] == 64'h0));

    // R1
    phase_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (wr_data[112] == $past(phase)));

    // R1
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ((wr_addr - $past(base)) < ADDR_W'(1 << OFS_W)));

endmodule

// File: rtl/cq_post_fsm.sv
module cq_post_fsm
    import cq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpl_valid,
    input  logic full,
    input  logic wr_ready,
    input  logic irq_en,
    output logic cpl_ready,
    output logic capture,
    output logic advance,
    output logic wr_valid,
    output logic irq_req
);

    cq_state_e state;
    cq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:   if (cpl_valid && !full) state_nx = ST_WRITE;
            ST_WRITE:  if (wr_ready)           state_nx = ST_SIGNAL;
            ST_SIGNAL:                         state_nx = ST_WAIT;
            default:                           state_nx = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        cpl_ready = 1'b0;
        capture   = 1'b0;
        advance   = 1'b0;
        wr_valid  = 1'b0;
        irq_req   = 1'b0;
        unique case (state)
            ST_WAIT: begin
                cpl_ready = !full;
                capture   = cpl_valid && !full;
            end
            ST_WRITE: begin
                wr_valid = 1'b1;
                advance  = wr_ready;
            end
            ST_SIGNAL: begin
                irq_req = irq_en;
            end
            default: begin
                cpl_ready = 1'b0;
            end
        endcase
    end

    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid);

    // R7
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && irq_en) |=> irq_req);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(wr_valid && wr_ready));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    // R8
    accept_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> (wr_valid && !cpl_ready));

    // R8
    one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_ready && wr_valid));

endmodule

// File: rtl/cq_poster.sv
module cq_poster
    import cq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_en,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic                cpl_valid,
    output logic                cpl_ready,
    input  logic [ID_W-1:0]     cpl_cid,
    input  logic [ID_W-1:0]     cpl_sqid,
    input  logic [ID_W-1:0]     cpl_sqhd,
    input  logic [STATUS_W-1:0] cpl_status,
    input  logic                db_valid,
    input  logic [IDX_W-1:0]    db_head,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [ENTRY_W-1:0]  wr_data,
    output logic                irq_req
);

    logic             full;
    logic             capture;
    logic             advance;
    logic             phase;
    logic [IDX_W-1:0] tail;
    cq_rec_t          rec;

    always_comb begin
        rec.status = cpl_status;
        rec.cid    = cpl_cid;
        rec.sqid   = cpl_sqid;
        rec.sqhd   = cpl_sqhd;
    end

    cq_post_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpl_valid (cpl_valid),
        .full      (full),
        .wr_ready  (wr_ready),
        .irq_en    (irq_en),
        .cpl_ready (cpl_ready),
        .capture   (capture),
        .advance   (advance),
        .wr_valid  (wr_valid),
        .irq_req   (irq_req)
    );

    cq_ring_ptr #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .db_valid (db_valid),
        .db_head  (db_head),
        .tail     (tail),
        .phase    (phase),
        .full     (full)
    );

    cq_entry_reg #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .rec     (rec),
        .phase   (phase),
        .slot    (tail),
        .base    (ring_base),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // R6
    stable_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(wr_addr) && $stable(wr_data)));

    // R4
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !cpl_ready);

endmodule

// File: tb/cq_poster_test.sv
module cq_poster_test;

    localparam int DEPTH  = 6;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 3;
    localparam logic [ADDR_W-1:0] BASE = 32'h8000_1200;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                irq_en = 1'b0;
    logic                cpl_valid = 1'b0;
    logic                cpl_ready;
    logic [15:0]         cpl_cid = '0;
    logic [15:0]         cpl_sqid = '0;
    logic [15:0]         cpl_sqhd = '0;
    logic [14:0]         cpl_status = '0;
    logic                db_valid = 1'b0;
    logic [IDX_W-1:0]    db_head = '0;
    logic                wr_valid;
    logic                wr_ready = 1'b1;
    logic [ADDR_W-1:0]   wr_addr;
    logic [127:0]        wr_data;
    logic                irq_req;

    int checks = 0;
    int fails  = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    int exp_tail = 0;
    int exp_head = 0;
    bit exp_phase = 1'b1;

    logic [ADDR_W+127:0] exp_q[$];
    bit irq_pending = 1'b0;
    bit irq_exp = 1'b0;

    always #10 clk = ~clk;

    cq_poster #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .ring_base(BASE),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_cid(cpl_cid),
        .cpl_sqid(cpl_sqid), .cpl_sqhd(cpl_sqhd), .cpl_status(cpl_status),
        .db_valid(db_valid), .db_head(db_head), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write-port readiness pattern
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            wr_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
        end
    end

    // monitor: compares writes against the expected queue, tracks interrupts
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_pending) begin
                check("R7 irq after write", 128'(irq_req), 128'(irq_exp));
                irq_pending = 1'b0;
            end else if (irq_req) begin
                check("R7 spurious irq", 128'(irq_req), 128'h0);
            end
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected write", 128'(wr_addr), 128'h0);
                end else begin
                    logic [ADDR_W+127:0] e;
                    e = exp_q.pop_front();
                    check("R2 R1 write address", 128'(wr_addr), 128'(e[ADDR_W+127:128]));
                    check("R1 R3 entry data", wr_data, e[127:0]);
                end
                irq_pending = 1'b1;
                irq_exp = irq_en;
            end
        end
    end

    // driver: offers one record and pushes its expected entry
    task automatic post(input logic [15:0] cid, input logic [15:0] sqid,
                        input logic [15:0] sqhd, input logic [14:0] st);
        logic [ADDR_W-1:0] a;
        logic [127:0] d;
        a = BASE + ADDR_W'(exp_tail * 16);
        d = {st, exp_phase, cid, sqid, sqhd, 64'h0};
        exp_q.push_back({a, d});
        if (exp_tail == DEPTH - 1) begin
            exp_tail = 0;
            exp_phase = ~exp_phase;
        end else begin
            exp_tail++;
        end
        @(posedge clk); #1;
        cpl_valid = 1'b1; cpl_cid = cid; cpl_sqid = sqid; cpl_sqhd = sqhd; cpl_status = st;
        forever begin
            @(negedge clk);
            if (cpl_ready) break;
        end
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        @(negedge clk);
        check("R8 ready low after accept", 128'(cpl_ready), 128'h0);
        check("R8 write follows accept", 128'(wr_valid), 128'h1);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic doorbell(input int h);
        @(posedge clk); #1;
        db_valid = 1'b1; db_head = IDX_W'(h);
        @(posedge clk); #1;
        db_valid = 1'b0;
        if (h < DEPTH) exp_head = h;
    endtask

    task automatic expect_blocked(input string req);
        @(posedge clk); #1;
        cpl_valid = 1'b1; cpl_cid = 16'hDEAD;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(req, {126'h0, cpl_ready, wr_valid}, 128'h0);
        end
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset cpl_ready", 128'(cpl_ready), 128'h1);
        check("R9 reset wr_valid", 128'(wr_valid), 128'h0);
        check("R9 reset irq_req", 128'(irq_req), 128'h0);

        irq_en = 1'b1;
        // out-of-order ids from several submission queues
        post(16'h0031, 16'h0002, 16'h0010, 15'h0000);
        post(16'h0007, 16'h0005, 16'h0004, 15'h1A2B);
        post(16'h0019, 16'h0002, 16'h0011, 15'h7FFF);
        stall_mode = 1'b1;
        post(16'hFFFF, 16'h0000, 16'hFFFF, 15'h0001);
        post(16'h0100, 16'hABCD, 16'h0020, 15'h4000);
        // tail 5, head 0: full
        expect_blocked("R4 full holds off input");
        doorbell(7);
        expect_blocked("R5 bad doorbell ignored");
        doorbell(4);
        irq_en = 1'b0;
        post(16'h0200, 16'h0001, 16'h0001, 15'h0123);
        post(16'h0201, 16'h0001, 16'h0002, 15'h0124);
        irq_en = 1'b1;
        stall_mode = 1'b0;
        post(16'h0202, 16'h0003, 16'h0003, 15'h0125);
        post(16'h0203, 16'h0003, 16'h0004, 15'h0126);
        // tail 3, head 4: full again
        expect_blocked("R4 full after wrap");
        doorbell(3);
        stall_mode = 1'b1;
        for (int k = 0; k < 5; k++) begin
            post(16'h0300 + 16'(k), 16'h0009, 16'(k), 15'(k * 7));
        end
        // phase went 1 -> 0 -> 1, tail 2, head 3
        expect_blocked("R3 R4 full after second wrap");
        check("R2 queue drained", 128'(exp_q.size()), 128'h0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule